// File: doc/BRIEF.md
# Fractional Clock-Enable Divider with Committed Ratio Update

The block derives up to two clock-enable streams from one parent clock. For each channel a 5-bit ratio field selects a multiplier `m = 32 - field`, between 1 and 32. A pulse-swallowing accumulator keeps `m` of every 32 parent cycles, spread as evenly as the arithmetic allows. A fixed divide-by-two stage then passes every second kept cycle. The enable rate is therefore `parent * m / 32 / 2`.

Software writes new ratios into a staging register. The channels keep running at their old rates until software sets the commit bit in a second register. At that moment the staged values are captured. They become active at the next 32-cycle window boundary, and the same clock edge clears the commit bit. Software polls that bit to learn when the change is complete. Because an update always lands on a window boundary, no window is ever cut short.

Top module: `fracdiv_kick`

## Requirements
- R1: After reset the ratio register reads 0, the commit bit reads 0, and each channel runs at full rate (32 enables in any 64 consecutive cycles).
- R2: The ratio register (selector 0) holds the primary channel's field in bits 12:8 and the secondary channel's field in bits 4:0. All other bits read as 0.
- R3: In steady state, any 64 consecutive cycles contain exactly `32 - field` enables on each channel.
- R4: A channel never asserts its enable in two consecutive cycles.
- R5: The commit register (selector 1) has its commit flag in bit 31. Writing 1 makes the flag read 1 from the next cycle. Writing 0 has no effect.
- R6: Writing the ratio register with no commit leaves the output rates unchanged.
- R7: A commit takes effect only at a 32-cycle window boundary. The flag clears on that same edge, at most 33 cycles after the commit write.
- R8: The values applied by a commit are those staged at the commit write. Ratio writes made while a commit is pending only update staging, and they take effect with the next commit.
- R9: Any 32 consecutive steady-state cycles contain `floor(m/2)` or `ceil(m/2)` enables per channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 ratio register, 1 commit register |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read target: 0 ratio register, 1 commit register |
| rd_data | output | 32 | Read data for the selected register |
| clk_en | output | NUM_CH | Per-channel clock enable, bit 0 primary |

## Verification
The rate function is exercised with field patterns at both ends of the range: 0 gives 32 enables per 64 cycles and 31 gives a single enable. Unequal mid-range values on the two channels show that the fields are independent and sit at the right bit positions. Each rate is measured over a 64-cycle span, which checks the exact count. A 32-cycle span catches an uneven swallowing pattern, since an uneven pattern still has the right average. Ratio writes made without a commit, and writes made while a commit is pending, show whether staging leaks into the active ratios before the intended update.

// File: rtl/fracdiv_pkg.sv
package fracdiv_pkg;
   localparam int REG_W    = 32;
   localparam int FIELD_W  = 5;
   localparam int WIN_LEN  = 32;
   localparam int CNT_W    = $clog2(WIN_LEN);
   localparam int MULT_W   = CNT_W + 1;
   localparam int KICK_BIT = 31;
   localparam int MAX_CH   = 2;

   // bit position of a channel's ratio field in the ratio register
   function automatic int field_lsb(input int ch);
      return (ch == 0) ? 8 : 0;
   endfunction
endpackage

// File: rtl/fracdiv_window.sv
module fracdiv_window #(
   parameter int WIN_LEN = 32,
   localparam int CNT_W = $clog2(WIN_LEN)
) (
   input  logic clk,
   input  logic rst_n,
   output logic win_last
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else if (win_last) cnt_q <= '0;
      else cnt_q <= cnt_q + 1'b1;
   end

   assign win_last = (cnt_q == CNT_W'(WIN_LEN - 1));
endmodule

// File: rtl/fracdiv_regs.sv
module fracdiv_regs
   import fracdiv_pkg::*;
#(
   parameter int NUM_CH = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic                            wr_sel,
   input  logic [REG_W-1:0]                wr_data,
   input  logic                            rd_sel,
   output logic [REG_W-1:0]                rd_data,
   input  logic                            win_last,
   output logic [NUM_CH-1:0][FIELD_W-1:0]  act_fields,
   output logic                            commit_pend
);
   logic [NUM_CH-1:0][FIELD_W-1:0] stage_q, snap_q, act_q;
   logic pend_q;
   logic ratio_wr, kick_wr;

   assign ratio_wr = wr_en && !wr_sel;
   assign kick_wr  = wr_en && wr_sel && wr_data[KICK_BIT] && !pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
      end else if (ratio_wr) begin
         for (int c = 0; c < NUM_CH; c++)
            stage_q[c] <= wr_data[field_lsb(c) +: FIELD_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_q <= '0;
         act_q  <= '0;
         pend_q <= 1'b0;
      end else if (kick_wr) begin
         snap_q <= stage_q;
         pend_q <= 1'b1;
      end else if (pend_q && win_last) begin
         act_q  <= snap_q;
         pend_q <= 1'b0;
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_sel) begin
         rd_data[KICK_BIT] = pend_q;
      end else begin
         for (int c = 0; c < NUM_CH; c++)
            rd_data[field_lsb(c) +: FIELD_W] = stage_q[c];
      end
   end

   assign act_fields  = act_q;
   assign commit_pend = pend_q;
endmodule

// File: rtl/fracdiv_chan.sv
module fracdiv_chan
   import fracdiv_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [FIELD_W-1:0] field,
   input  logic               win_last,
   output logic               en_o
);
   logic [CNT_W-1:0]  acc_q;
   logic [MULT_W-1:0] mult, sum;
   logic              keep, half_q, en_q;

   assign mult = MULT_W'(WIN_LEN) - MULT_W'(field);
   assign sum  = MULT_W'(acc_q) + mult;
   assign keep = (sum >= MULT_W'(WIN_LEN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         half_q <= 1'b0;
         en_q   <= 1'b0;
      end else begin
         if (win_last) acc_q <= '0;
         else if (keep) acc_q <= CNT_W'(sum - MULT_W'(WIN_LEN));
         else acc_q <= CNT_W'(sum);
         if (keep) half_q <= ~half_q;
         en_q <= keep && half_q;
      end
   end

   assign en_o = en_q;
endmodule

// File: rtl/fracdiv_kick.sv
module fracdiv_kick
   import fracdiv_pkg::*;
#(
   parameter int NUM_CH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [31:0]       wr_data,
   input  logic              rd_sel,
   output logic [31:0]       rd_data,
   output logic [NUM_CH-1:0] clk_en
);
   generate
      if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_ch
         $error("fracdiv_kick: NUM_CH must be 1 or 2");
      end
   endgenerate

   logic                           win_last;
   logic                           commit_pend;
   logic [NUM_CH-1:0][FIELD_W-1:0] act_fields;

   fracdiv_window #(.WIN_LEN(WIN_LEN)) win_i (
      .clk(clk), .rst_n(rst_n), .win_last(win_last)
   );

   fracdiv_regs #(.NUM_CH(NUM_CH)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
      .win_last(win_last), .act_fields(act_fields),
      .commit_pend(commit_pend)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         fracdiv_chan chan_i (
            .clk(clk), .rst_n(rst_n), .field(act_fields[c]),
            .win_last(win_last), .en_o(clk_en[c])
         );
      end
   endgenerate
endmodule

// File: rtl/fracdiv_kick_chk.sv
module fracdiv_kick_chk
   import fracdiv_pkg::*;
#(
   parameter int NUM_CH = 2
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           wr_en,
   input logic                           wr_sel,
   input logic [31:0]                    wr_data,
   input logic                           win_last,
   input logic                           commit_pend,
   input logic [NUM_CH-1:0][FIELD_W-1:0] act_fields,
   input logic [NUM_CH-1:0]              clk_en
);
   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         // R4
         no_b2b_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clk_en[c] |=> !clk_en[c]);
      end
   endgenerate

   // R7
   pend_clear_at_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(commit_pend) |-> $past(win_last));

   // R7
   active_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_fields) |-> $past(win_last && commit_pend));

   // R5
   kick_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel && wr_data[KICK_BIT]) |=> commit_pend);

   // R5
   zero_write_no_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel && !wr_data[KICK_BIT] && !commit_pend) |=> !commit_pend);
endmodule

bind fracdiv_kick fracdiv_kick_chk #(.NUM_CH(NUM_CH)) chk_i (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
   .wr_data(wr_data), .win_last(win_last), .commit_pend(commit_pend),
   .act_fields(act_fields), .clk_en(clk_en)
);

// File: tb/fracdiv_kick_tb_top.sv
module fracdiv_kick_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_sel = 1'b0;
   logic [31:0] rd_data;
   logic [1:0]  clk_en;

   int checks = 0;
   int fails = 0;
   int b2b_hits = 0;
   logic prev0 = 1'b0, prev1 = 1'b0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   fracdiv_kick #(.NUM_CH(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
      .clk_en(clk_en)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (clk_en[0] && prev0) b2b_hits++;
         if (clk_en[1] && prev1) b2b_hits++;
         prev0 = clk_en[0];
         prev1 = clk_en[1];
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic write_reg(input bit sel, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic read_reg(input bit sel, output logic [31:0] d);
      rd_sel = sel;
      #1 d = rd_data;
   endtask

   task automatic measure(input int n, output int c0, output int c1);
      c0 = 0; c1 = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (clk_en[0]) c0++;
         if (clk_en[1]) c1++;
      end
   endtask

   // expects write_reg(1, kick) to have just returned
   task automatic wait_commit(input string req);
      int polls = 0;
      logic [31:0] d;
      read_reg(1'b1, d);
      chk("R5 flag set after kick", int'(d[31]), 1);
      while (d[31] && polls < 100) begin
         @(negedge clk);
         polls++;
         read_reg(1'b1, d);
      end
      checks++;
      if (polls > 33) begin
         fails++;
         $display("FAIL R7 %s: commit latency actual %0d expected <= 33", req, polls);
      end
      @(negedge clk);
   endtask

   task automatic check_rates(input string req, input int m0, input int m1);
      int c0, c1;
      measure(64, c0, c1);
      chk({req, " R3 ch0 rate"}, c0, m0);
      chk({req, " R3 ch1 rate"}, c1, m1);
   endtask

   task automatic check_even(input int m0, input int m1);
      int c0, c1;
      measure(32, c0, c1);
      checks++;
      if (c0 != m0 / 2 && c0 != (m0 + 1) / 2) begin
         fails++;
         $display("FAIL R9 ch0: actual %0d expected %0d or %0d", c0, m0 / 2, (m0 + 1) / 2);
      end
      checks++;
      if (c1 != m1 / 2 && c1 != (m1 + 1) / 2) begin
         fails++;
         $display("FAIL R9 ch1: actual %0d expected %0d or %0d", c1, m1 / 2, (m1 + 1) / 2);
      end
   endtask

   task automatic t_reset;
      logic [31:0] d;
      read_reg(1'b0, d);
      chk("R1 ratio reg after reset", int'(d), 0);
      read_reg(1'b1, d);
      chk("R1 commit reg after reset", int'(d), 0);
      check_rates("R1", 32, 32);
   endtask

   task automatic t_layout_and_staging;
      logic [31:0] d;
      write_reg(1'b0, 32'hFFFF_FFFF);
      read_reg(1'b0, d);
      chk("R2 readback of all-ones write", int'(d), 32'h0000_1F1F);
      check_rates("R6 staged only", 32, 32);
   endtask

   task automatic t_min_rate;
      write_reg(1'b1, 32'h8000_0000);
      wait_commit("min rate");
      check_rates("R3 field 31", 1, 1);
      check_even(1, 1);
   endtask

   task automatic t_mixed;
      write_reg(1'b0, (32'd12 << 8) | 32'd23);
      write_reg(1'b1, 32'h8000_0000);
      wait_commit("mixed");
      check_rates("R2 mixed fields", 20, 9);
      check_even(20, 9);
   endtask

   task automatic t_write_while_pending;
      logic [31:0] d;
      write_reg(1'b0, 32'd16);
      write_reg(1'b1, 32'h8000_0000);
      write_reg(1'b0, (32'd5 << 8) | 32'd30);
      wait_commit("pending write");
      check_rates("R8 snapshot applied", 32, 16);
      read_reg(1'b0, d);
      chk("R8 staging holds later write", int'(d), (5 << 8) | 30);
      write_reg(1'b1, 32'h8000_0000);
      wait_commit("second commit");
      check_rates("R8 next commit", 27, 2);
      check_even(27, 2);
   endtask

   task automatic t_zero_kick;
      logic [31:0] d;
      write_reg(1'b0, 32'd0);
      write_reg(1'b1, 32'h7FFF_FFFF);
      read_reg(1'b1, d);
      chk("R5 zero kick leaves flag clear", int'(d[31]), 0);
      check_rates("R5 zero kick no change", 27, 2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_layout_and_staging();
      t_min_rate();
      t_mixed();
      t_write_while_pending();
      t_zero_kick();
      chk("R4 back-to-back enables", b2b_hits, 0);
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule